// File: doc/BRIEF.md
# Per-Tick Performance-Level Switching Sequencer

This block is the power controller of a single processing element. It picks one of three performance levels and moves the element between them. Level 0 pairs a 0.7 V rail with 125 MHz, level 1 pairs 0.85 V with 333 MHz, and level 2 pairs 1.0 V with 500 MHz.

A new level can come from two places. On each real-time tick (nominally every millisecond), the measured workload is compared with two programmable thresholds. Separately, a level request can arrive from the on-chip network.

When the chosen level differs from the current one, the block runs a fixed hardware sequence:
1. Stop the core clock.
2. Partly pre-charge the new rail.
3. Switch the main rail.
4. Retarget the clock generator and wait for it to lock.
5. Restart the clock.

Every step except the lock wait takes a programmable number of cycles. With the default settings at 200 MHz, a transition takes 10 cycles (50 ns). This keeps the whole change inside the 100 ns budget. If lock does not arrive before a programmable limit, the block goes back to its old level and raises an error flag. A demand that arrives during a transition waits in a single pending slot. A newer demand replaces the one waiting there.

Top module: `pwr_lvl_seq`

## Requirements
- R1: After reset the block is idle at level 2: `cur_lvl_o`=2, `rail_sel_o`=3'b100, `pll_code_o`=2, `clk_en_o`=1, `pchg_en_o`=0, `busy_o`=0, `lock_err_o`=0.
- R2: The workload is read only in a cycle where `tick_i` is 1. It selects level 0 when `workload_i` < `thr_a_i`, level 1 when it is not below `thr_a_i` but below `thr_b_i`, and level 2 otherwise. A workload change without a tick starts nothing.
- R3: `req_vld_i` demands level `req_lvl_i`. A request wins over a tick in the same cycle. A request value of 3 is treated as level 2.
- R4: A demand for the level already held starts no sequence and leaves all outputs unchanged.
- R5: The steps run in this order: gate, pre-charge, rail, relock, ungate.
  - The clock is off in the gate, pre-charge and rail steps.
  - `pchg_en_o` is 1 only in the pre-charge step.
  - `rail_sel_o` moves to the new level when the rail step starts.
  - `pll_code_o` moves to the new level when the relock step starts.
  - `clk_en_o` returns to 1 when the ungate step starts.
- R6: Each of the gate, pre-charge, rail and ungate steps lasts max(N,1) cycles, where N is its count input. The relock step ends in the first cycle in which `pll_lock_i` is sampled as 1. `busy_o` stays high for exactly the sum of these step lengths.
- R7: If relock has lasted max(`lock_limit_i`,1) cycles without lock, the block does the following:
  - It raises `lock_err_o`.
  - It returns the rail and the PLL code to the old level, with the clock still off, for one rail-step length.
  - It then runs the ungate step and stays at the old level.
  - `lock_err_o` stays high until the next sequence starts.
- R8: A demand that arrives while busy is held in a single slot, and the newest demand replaces it. The held demand is taken as soon as the block is idle and runs only if it differs from the current level.
- R9: `rail_sel_o` always has exactly one bit set: bit i means level i. The pre-charge enable is never 1 while the clock is enabled or after the rail has switched.
- R10: `cur_lvl_o` takes the new level only when lock is seen. `busy_o` is 1 from the cycle after a demand is taken until the end of the ungate step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Real-time tick strobe |
| workload_i | input | WL_W | Measured workload |
| thr_a_i | input | WL_W | Threshold between level 0 and level 1 |
| thr_b_i | input | WL_W | Threshold between level 1 and level 2 |
| req_vld_i | input | 1 | Direct level request strobe |
| req_lvl_i | input | 2 | Requested level |
| cyc_gate_i | input | CNT_W | Cycles of the clock-off step |
| cyc_pchg_i | input | CNT_W | Cycles of the pre-charge step |
| cyc_rail_i | input | CNT_W | Cycles of the rail-switch step (also used for the revert step) |
| cyc_ungate_i | input | CNT_W | Cycles of the clock-restart step |
| lock_limit_i | input | CNT_W | Maximum number of relock cycles |
| pll_lock_i | input | 1 | Clock generator lock indication |
| rail_sel_o | output | 3 | One-hot header-switch rail select |
| pchg_en_o | output | 1 | Pre-charge enable |
| pll_code_o | output | 2 | Clock generator target code (the level number) |
| clk_en_o | output | 1 | Core clock enable |
| busy_o | output | 1 | Transition in progress |
| cur_lvl_o | output | 2 | Current level |
| lock_err_o | output | 1 | Lock timeout flag |

## Verification
The bench checks every output cycle by cycle against a step timeline that it builds from the programmed counts. It covers the following corner cases:
- **Threshold boundaries.** A workload exactly equal to a threshold must select the higher level. A design that uses ≤ instead of < would pick the lower one.
- **Request and tick in the same cycle.** The request must win. A design that lets the tick win would move to the wrong level.
- **Two requests during one transition.** The newest must win. A design that keeps the first request would run its second transition to the wrong level.
- **Held demand equal to the new level.** No transition may follow. A design that does not compare the held demand would show an extra busy period.
- **Lock timeout.** The block must return to the old level and raise the error flag. A design that gets this wrong would end at the new level or leave the flag low.
- **Late lock.** A lock that arrives several cycles into the relock step must stretch the busy period by exactly that many cycles.
- **Zero step count.** A count of zero must last one cycle. A design that treats zero as "no step" would shorten the busy period.

// File: rtl/pls_pkg.sv
package pls_pkg;
  localparam int NUM_LVL = 3;
  localparam int LVL_W   = 2;
  localparam logic [LVL_W-1:0] TOP_LVL = LVL_W'(NUM_LVL - 1);

  typedef logic [LVL_W-1:0] lvl_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GATE,
    ST_PCHG,
    ST_RAIL,
    ST_RELOCK,
    ST_REVERT,
    ST_UNGATE
  } step_e;
endpackage

// File: rtl/pls_lvl_map.sv
module pls_lvl_map
  import pls_pkg::*;
#(
  parameter int WL_W = 16
) (
  input  logic            tick_i,
  input  logic [WL_W-1:0] workload_i,
  input  logic [WL_W-1:0] thr_a_i,
  input  logic [WL_W-1:0] thr_b_i,
  input  logic            req_vld_i,
  input  lvl_t            req_lvl_i,
  output logic            dem_vld_o,
  output lvl_t            dem_lvl_o
);
  lvl_t tick_lvl;
  lvl_t req_lvl_c;

  // Workload to level, lowest band first
  always_comb begin
    if (workload_i < thr_a_i) begin
      tick_lvl = '0;
    end else if (workload_i < thr_b_i) begin
      tick_lvl = LVL_W'(1);
    end else begin
      tick_lvl = TOP_LVL;
    end
  end

  // Out-of-range request saturates at the top level
  assign req_lvl_c = (req_lvl_i > TOP_LVL) ? TOP_LVL : req_lvl_i;

  // A direct request has priority over the tick decision
  assign dem_vld_o = req_vld_i | tick_i;
  assign dem_lvl_o = req_vld_i ? req_lvl_c : tick_lvl;
endmodule

// File: rtl/pls_pend.sv
module pls_pend
  import pls_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic dem_vld_i,
  input  lvl_t dem_lvl_i,
  input  logic take_i,
  output logic pend_vld_o,
  output lvl_t pend_lvl_o
);
  logic vld_q, vld_d;
  lvl_t lvl_q, lvl_d;

  always_comb begin
    vld_d = vld_q;
    lvl_d = lvl_q;
    if (dem_vld_i) begin
      vld_d = 1'b1;
      lvl_d = dem_lvl_i;
    end else if (take_i) begin
      vld_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      lvl_q <= TOP_LVL;
    end else begin
      vld_q <= vld_d;
      if (dem_vld_i) begin
        lvl_q <= lvl_d;
      end
    end
  end

  assign pend_vld_o = vld_q;
  assign pend_lvl_o = lvl_q;
endmodule

// File: rtl/pls_step_fsm.sv
module pls_step_fsm
  import pls_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pend_vld_i,
  input  lvl_t             pend_lvl_i,
  input  logic [CNT_W-1:0] cyc_gate_i,
  input  logic [CNT_W-1:0] cyc_pchg_i,
  input  logic [CNT_W-1:0] cyc_rail_i,
  input  logic [CNT_W-1:0] cyc_ungate_i,
  input  logic [CNT_W-1:0] lock_limit_i,
  input  logic             pll_lock_i,
  output logic             take_o,
  output step_e            state_o,
  output lvl_t             cur_o,
  output lvl_t             tgt_o,
  output logic             err_o
);
  localparam logic [CNT_W:0] ONE = (CNT_W+1)'(1);

  step_e            state_q, state_d;
  lvl_t             cur_q, cur_d, tgt_q, tgt_d;
  logic             err_q, err_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic [CNT_W:0]   raw_len, len, cnt_p1;
  logic             step_done;

  // Length of the current step, zero counts as one cycle
  always_comb begin
    unique case (state_q)
      ST_GATE:   raw_len = {1'b0, cyc_gate_i};
      ST_PCHG:   raw_len = {1'b0, cyc_pchg_i};
      ST_RAIL:   raw_len = {1'b0, cyc_rail_i};
      ST_RELOCK: raw_len = {1'b0, lock_limit_i};
      ST_REVERT: raw_len = {1'b0, cyc_rail_i};
      ST_UNGATE: raw_len = {1'b0, cyc_ungate_i};
      default:   raw_len = ONE;
    endcase
  end

  assign len       = (raw_len == '0) ? ONE : raw_len;
  assign cnt_p1    = {1'b0, cnt_q} + ONE;
  assign step_done = (cnt_p1 >= len);

  // Next-state logic
  always_comb begin
    state_d = state_q;
    cur_d   = cur_q;
    tgt_d   = tgt_q;
    err_d   = err_q;
    take_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        take_o = pend_vld_i;
        if (pend_vld_i && (pend_lvl_i != cur_q)) begin
          state_d = ST_GATE;
          tgt_d   = pend_lvl_i;
          err_d   = 1'b0;
        end
      end
      ST_GATE:   if (step_done) state_d = ST_PCHG;
      ST_PCHG:   if (step_done) state_d = ST_RAIL;
      ST_RAIL:   if (step_done) state_d = ST_RELOCK;
      ST_RELOCK: begin
        if (pll_lock_i) begin
          state_d = ST_UNGATE;
          cur_d   = tgt_q;
        end else if (step_done) begin
          state_d = ST_REVERT;
          err_d   = 1'b1;
        end
      end
      ST_REVERT: if (step_done) state_d = ST_UNGATE;
      ST_UNGATE: if (step_done) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  // Step counter: counts only during a sequence, clears on every step change
  assign cnt_en = (state_q != ST_IDLE);
  assign cnt_d  = (state_d != state_q) ? '0 : cnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cur_q   <= TOP_LVL;
      tgt_q   <= TOP_LVL;
      err_q   <= 1'b0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cur_q   <= cur_d;
      tgt_q   <= tgt_d;
      err_q   <= err_d;
      if (cnt_en) begin
        cnt_q <= cnt_d;
      end
    end
  end

  assign state_o = state_q;
  assign cur_o   = cur_q;
  assign tgt_o   = tgt_q;
  assign err_o   = err_q;
endmodule

// File: rtl/pls_out_dec.sv
module pls_out_dec
  import pls_pkg::*;
(
  input  step_e              state_i,
  input  lvl_t               cur_i,
  input  lvl_t               tgt_i,
  output logic [NUM_LVL-1:0] rail_sel_o,
  output lvl_t               pll_code_o,
  output logic               pchg_en_o,
  output logic               clk_en_o,
  output logic               busy_o
);
  lvl_t rail_lvl;

  assign rail_lvl = ((state_i == ST_RAIL) || (state_i == ST_RELOCK)) ? tgt_i : cur_i;

  for (genvar i = 0; i < NUM_LVL; i++) begin : g_rail
    assign rail_sel_o[i] = (rail_lvl == LVL_W'(i));
  end

  assign pll_code_o = (state_i == ST_RELOCK) ? tgt_i : cur_i;
  assign pchg_en_o  = (state_i == ST_PCHG);
  assign clk_en_o   = (state_i == ST_IDLE) || (state_i == ST_UNGATE);
  assign busy_o     = (state_i != ST_IDLE);
endmodule

// File: rtl/pwr_lvl_seq.sv
module pwr_lvl_seq
  import pls_pkg::*;
#(
  parameter int WL_W  = 16,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic [WL_W-1:0]  workload_i,
  input  logic [WL_W-1:0]  thr_a_i,
  input  logic [WL_W-1:0]  thr_b_i,
  input  logic             req_vld_i,
  input  logic [1:0]       req_lvl_i,
  input  logic [CNT_W-1:0] cyc_gate_i,
  input  logic [CNT_W-1:0] cyc_pchg_i,
  input  logic [CNT_W-1:0] cyc_rail_i,
  input  logic [CNT_W-1:0] cyc_ungate_i,
  input  logic [CNT_W-1:0] lock_limit_i,
  input  logic             pll_lock_i,
  output logic [2:0]       rail_sel_o,
  output logic             pchg_en_o,
  output logic [1:0]       pll_code_o,
  output logic             clk_en_o,
  output logic             busy_o,
  output logic [1:0]       cur_lvl_o,
  output logic             lock_err_o
);
  // Reset asserts at once and releases on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  logic  dem_vld, pend_vld, take;
  lvl_t  dem_lvl, pend_lvl, cur_lvl, tgt_lvl;
  step_e state;

  pls_lvl_map #(.WL_W(WL_W)) u_map (
    .tick_i     (tick_i),
    .workload_i (workload_i),
    .thr_a_i    (thr_a_i),
    .thr_b_i    (thr_b_i),
    .req_vld_i  (req_vld_i),
    .req_lvl_i  (req_lvl_i),
    .dem_vld_o  (dem_vld),
    .dem_lvl_o  (dem_lvl)
  );

  pls_pend u_pend (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .dem_vld_i  (dem_vld),
    .dem_lvl_i  (dem_lvl),
    .take_i     (take),
    .pend_vld_o (pend_vld),
    .pend_lvl_o (pend_lvl)
  );

  pls_step_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .pend_vld_i   (pend_vld),
    .pend_lvl_i   (pend_lvl),
    .cyc_gate_i   (cyc_gate_i),
    .cyc_pchg_i   (cyc_pchg_i),
    .cyc_rail_i   (cyc_rail_i),
    .cyc_ungate_i (cyc_ungate_i),
    .lock_limit_i (lock_limit_i),
    .pll_lock_i   (pll_lock_i),
    .take_o       (take),
    .state_o      (state),
    .cur_o        (cur_lvl),
    .tgt_o        (tgt_lvl),
    .err_o        (lock_err_o)
  );

  pls_out_dec u_dec (
    .state_i    (state),
    .cur_i      (cur_lvl),
    .tgt_i      (tgt_lvl),
    .rail_sel_o (rail_sel_o),
    .pll_code_o (pll_code_o),
    .pchg_en_o  (pchg_en_o),
    .clk_en_o   (clk_en_o),
    .busy_o     (busy_o)
  );

  assign cur_lvl_o = cur_lvl;
endmodule

// File: rtl/pls_chk.sv
module pls_chk
  import pls_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_LVL-1:0] rail_sel,
  input logic               pchg_en,
  input logic [1:0]         pll_code,
  input logic               clk_en,
  input logic               busy,
  input logic [1:0]         cur_lvl,
  input logic               lock_err
);
  logic [NUM_LVL-1:0] cur_oh;
  assign cur_oh = NUM_LVL'(1) << cur_lvl;

  // R9
  rail_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rail_sel) == 1);

  // R9
  pchg_clk_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pchg_en |-> !clk_en);

  // R5
  pchg_old_rail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pchg_en |-> (rail_sel == cur_oh));

  // R5
  rail_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rail_sel != $past(rail_sel)) |-> (!clk_en && !pchg_en));

  // R5
  code_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pll_code != $past(pll_code)) |-> !clk_en);

  // R10
  clk_off_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |-> busy);

  // R10
  lvl_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_lvl != $past(cur_lvl)) |-> $past(busy));

  // R7
  err_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_err) |-> (busy && !clk_en));
endmodule

bind pwr_lvl_seq pls_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rail_sel (rail_sel_o),
  .pchg_en  (pchg_en_o),
  .pll_code (pll_code_o),
  .clk_en   (clk_en_o),
  .busy     (busy_o),
  .cur_lvl  (cur_lvl_o),
  .lock_err (lock_err_o)
);

// File: tb/tb_pwr_lvl_seq.sv
`timescale 1ns/1ps
module tb_pwr_lvl_seq;
  localparam int WL_W  = 16;
  localparam int CNT_W = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_i = 1'b0;
  logic [WL_W-1:0] workload_i = '0;
  logic [WL_W-1:0] thr_a_i = 16'd100;
  logic [WL_W-1:0] thr_b_i = 16'd200;
  logic req_vld_i = 1'b0;
  logic [1:0] req_lvl_i = '0;
  logic [CNT_W-1:0] cyc_gate_i, cyc_pchg_i, cyc_rail_i, cyc_ungate_i, lock_limit_i;
  logic pll_lock_i = 1'b1;
  logic [2:0] rail_sel_o;
  logic pchg_en_o, clk_en_o, busy_o, lock_err_o;
  logic [1:0] pll_code_o, cur_lvl_o;

  always #2.5 clk = ~clk;

  pwr_lvl_seq #(.WL_W(WL_W), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .workload_i(workload_i),
    .thr_a_i(thr_a_i), .thr_b_i(thr_b_i), .req_vld_i(req_vld_i), .req_lvl_i(req_lvl_i),
    .cyc_gate_i(cyc_gate_i), .cyc_pchg_i(cyc_pchg_i), .cyc_rail_i(cyc_rail_i),
    .cyc_ungate_i(cyc_ungate_i), .lock_limit_i(lock_limit_i), .pll_lock_i(pll_lock_i),
    .rail_sel_o(rail_sel_o), .pchg_en_o(pchg_en_o), .pll_code_o(pll_code_o),
    .clk_en_o(clk_en_o), .busy_o(busy_o), .cur_lvl_o(cur_lvl_o), .lock_err_o(lock_err_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  int n_seq = 0;
  int gv = 2, pv = 3, rv = 2, uv = 2, tv = 6;
  int lock_mode = 0;

  typedef struct {
    int o; int n; int g; int p; int r; int lw; int u; bit e;
  } exp_t;
  exp_t sbq[$];

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic apply_counts();
    cyc_gate_i   = CNT_W'(gv);
    cyc_pchg_i   = CNT_W'(pv);
    cyc_rail_i   = CNT_W'(rv);
    cyc_ungate_i = CNT_W'(uv);
    lock_limit_i = CNT_W'(tv);
  endtask

  // Driver side: push the expected transition
  task automatic push(input int o, input int n, input int lw, input bit e);
    exp_t it;
    it.o = o; it.n = n; it.g = eff(gv); it.p = eff(pv); it.r = eff(rv);
    it.lw = lw; it.u = eff(uv); it.e = e;
    sbq.push_back(it);
  endtask

  task automatic req(input int l);
    @(negedge clk);
    req_vld_i = 1'b1;
    req_lvl_i = 2'(l);
    @(negedge clk);
    req_vld_i = 1'b0;
  endtask

  task automatic tick(input int wl);
    @(negedge clk);
    workload_i = WL_W'(wl);
    tick_i = 1'b1;
    @(negedge clk);
    tick_i = 1'b0;
  endtask

  task automatic wait_idle();
    int q = 0;
    for (int i = 0; i < 300 && q < 4; i++) begin
      @(negedge clk);
      q = busy_o ? 0 : q + 1;
    end
  endtask

  // Lock model
  int lk_cnt = 0;
  logic [1:0] prev_code = 2'd0;
  always @(negedge clk) begin
    if (pll_code_o != prev_code) lk_cnt = 0;
    else if (lk_cnt < 15) lk_cnt++;
    prev_code = pll_code_o;
    case (lock_mode)
      0: pll_lock_i = 1'b1;
      1: pll_lock_i = 1'b0;
      default: pll_lock_i = (lk_cnt >= 3);
    endcase
  end

  // Monitor: pop expected items and compare every step cycle
  bit in_seq = 0;
  bit have = 0;
  bit shape_ok, guard_ok;
  int c = 0;
  int bad_c;
  exp_t ce;
  always @(negedge clk) begin
    if (!rst_n) begin
      in_seq = 0;
    end else begin
      if (busy_o && !in_seq) begin
        in_seq = 1; c = 0; n_seq++; shape_ok = 1; guard_ok = 1; bad_c = -1;
        if (sbq.size() > 0) begin
          ce = sbq.pop_front(); have = 1;
        end else begin
          have = 0;
          chk(0, "R4", "unexpected sequence start", 1, 0);
        end
      end
      if (in_seq && busy_o) begin
        if ($countones(rail_sel_o) != 1 || (pchg_en_o && clk_en_o)) guard_ok = 0;
        if (have) begin
          int a, b, d, f, h, rl, cl;
          bit ck, pc;
          a = ce.g; b = a + ce.p; d = b + ce.r; f = d + ce.lw; h = f + ce.r;
          pc = (c >= a) && (c < b);
          if (!ce.e) begin
            rl = (c >= b) ? ce.n : ce.o;
            cl = (c >= d) ? ce.n : ce.o;
            ck = (c >= f);
          end else begin
            rl = (c >= b && c < f) ? ce.n : ce.o;
            cl = (c >= d && c < f) ? ce.n : ce.o;
            ck = (c >= h);
          end
          if (rail_sel_o != 3'(1 << rl) || pll_code_o != 2'(cl) ||
              clk_en_o != ck || pchg_en_o != pc) begin
            if (shape_ok) bad_c = c;
            shape_ok = 0;
          end
        end
        c++;
      end else if (in_seq && !busy_o) begin
        in_seq = 0;
        if (have) begin
          int tot;
          tot = ce.g + ce.p + ce.r + ce.lw + ce.u + (ce.e ? ce.r : 0);
          chk(c == tot, "R6", "busy length", c, tot);
          chk(shape_ok, "R5", "step outputs, first bad cycle", bad_c, -1);
          chk(guard_ok, "R9", "onehot rail / precharge guard", 0, 1);
          chk(cur_lvl_o == 2'(ce.e ? ce.o : ce.n), "R10", "level after sequence",
              int'(cur_lvl_o), ce.e ? ce.o : ce.n);
          chk(lock_err_o == ce.e, "R7", "lock error flag", int'(lock_err_o), int'(ce.e));
        end
      end
    end
  end

  task automatic finish_up();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "R1", "watchdog expired", 0, 1);
    finish_up();
  end

  initial begin
    int s;
    apply_counts();
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(cur_lvl_o == 2'd2, "R1", "reset level", int'(cur_lvl_o), 2);
    chk(rail_sel_o == 3'b100, "R1", "reset rail", int'(rail_sel_o), 4);
    chk(pll_code_o == 2'd2, "R1", "reset code", int'(pll_code_o), 2);
    chk(clk_en_o && !pchg_en_o && !busy_o && !lock_err_o, "R1", "reset flags",
        int'({clk_en_o, pchg_en_o, busy_o, lock_err_o}), 8);

    // R3 direct request
    push(2, 0, 1, 0); req(0); wait_idle();

    // R4 request for current level
    s = n_seq; req(0); wait_idle();
    chk(n_seq == s && cur_lvl_o == 2'd0, "R4", "no sequence for same level", n_seq - s, 0);

    // R2 workload change without tick
    s = n_seq; workload_i = 16'd250; repeat (8) @(negedge clk);
    chk(n_seq == s, "R2", "no action without tick", n_seq - s, 0);

    // R2 threshold bands and boundaries
    push(0, 1, 1, 0); tick(150); wait_idle();
    push(1, 2, 1, 0); tick(250); wait_idle();
    push(2, 0, 1, 0); tick(99);  wait_idle();
    push(0, 1, 1, 0); tick(100); wait_idle();
    s = n_seq; tick(199); wait_idle();
    chk(n_seq == s && cur_lvl_o == 2'd1, "R2", "band 1 upper edge", int'(cur_lvl_o), 1);
    push(1, 2, 1, 0); tick(200); wait_idle();

    // R3 request beats tick in the same cycle
    push(2, 0, 1, 0);
    @(negedge clk);
    workload_i = 16'd150; tick_i = 1'b1; req_vld_i = 1'b1; req_lvl_i = 2'd0;
    @(negedge clk);
    tick_i = 1'b0; req_vld_i = 1'b0;
    wait_idle();

    // R3 out-of-range request maps to level 2
    push(0, 2, 1, 0); req(3); wait_idle();

    // R8 newest pending demand wins
    s = n_seq;
    push(2, 1, 1, 0); push(1, 2, 1, 0);
    req(1); repeat (3) @(negedge clk); req(0); req(2); wait_idle();
    chk(n_seq == s + 2, "R8", "pending overwrite sequences", n_seq - s, 2);

    // R8 pending equal to new level is dropped
    s = n_seq;
    push(2, 0, 1, 0);
    req(0); repeat (3) @(negedge clk); req(0); wait_idle();
    chk(n_seq == s + 1, "R8", "stale pending dropped", n_seq - s, 1);

    // R7 lock timeout reverts
    lock_mode = 1;
    push(0, 1, tv, 1); req(1); wait_idle();
    chk(lock_err_o == 1'b1 && cur_lvl_o == 2'd0, "R7", "error held when idle",
        int'({lock_err_o, cur_lvl_o}), 4);
    lock_mode = 0; repeat (2) @(negedge clk);
    push(0, 2, 1, 0); req(2); wait_idle();

    // R6 late lock stretches relock
    lock_mode = 2; repeat (2) @(negedge clk);
    push(2, 1, 4, 0); req(1); wait_idle();
    lock_mode = 0;

    // R6 other step counts, zero treated as one
    gv = 1; pv = 0; rv = 4; uv = 3; apply_counts();
    push(1, 0, 1, 0); req(0); wait_idle();

    chk(sbq.size() == 0, "R10", "all expected sequences seen", sbq.size(), 0);
    finish_up();
  end
endmodule